// File: doc/BRIEF.md
# Serial Horner Polynomial Evaluator

This block evaluates a cubic polynomial f(x) = c3·x³ + c2·x² + c1·x + c0 for unsigned operands using Horner's rule. The four coefficients enter on one port, one per clock cycle, highest order first. The evaluation point stays constant on its own port for the whole evaluation. One multiply-accumulate stage folds each coefficient into a running accumulator. A rotating one-hot phase register marks the cycle in which the last coefficient is present. On that edge the finished value is captured.

The output register changes only on capture edges. A downstream consumer therefore sees a stable, complete result for four cycles and never sees a partial sum. Evaluations run back to back: after each capture the accumulator restarts, so the next group of four coefficients can follow with no gap.

Coefficient width, point width and result width are parameters. All arithmetic wraps modulo 2^OUT_W, because the accumulator fed back into the sum holds only OUT_W bits.

Top module: `horner_eval`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the accumulator clears to zero, `fx` clears to zero and the phase register returns to its start value. The first coefficient presented in the cycle after reset is released is treated as c3.
- R2: After the four edges on which c3, c2, c1 and c0 are sampled in that order, `fx` equals c3·x³ + c2·x² + c1·x + c0. The value x is held constant during those four cycles.
- R3: All sums and products are reduced modulo 2^OUT_W. A polynomial value at or above 2^OUT_W appears on `fx` as its low OUT_W bits.
- R4: `fx` changes only on the edge that samples c0. On the other three edges of each evaluation it keeps the previous result, or zero after reset.
- R5: The phase register holds exactly one set bit and rotates by one position on every edge, with a period of four edges.
- R6: The edge that samples c0 also restarts the accumulator at zero. Consecutive evaluations are therefore independent, with no idle cycle between them.
- R7: The widths are parameters. With 4-bit coefficients, a 3-bit point and a 16-bit result, x = 2 and coefficients 0, 7, 5, 2 give 40. With the default 3/2/9 widths, x = 3 and coefficients 5, 6, 2, 0 give 195.
- R8: With x = 0 the result equals c0 alone, whatever the higher coefficients are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ai | input | COEF_W | Serial coefficient, c3 first and c0 last |
| x | input | PT_W | Evaluation point, held for each evaluation |
| fx | output | OUT_W | Last completed polynomial value |

## Verification
A phase register that is out of step or holds more than one set bit makes `fx` change on the wrong edge. It would then show the partial sum c3·x + c2 or similar. The first evaluation after reset exposes this within four cycles, through a hold check or a value check. If the accumulator does not restart, the error is not visible in the first result: the second of two back-to-back evaluations comes out too large. A truncation fault only shows when the polynomial value overflows the result width, so a narrow-result instance is driven with the same vectors.

// File: rtl/horner_pkg.sv
// Shared constants for the serial Horner evaluator.
// Assumes a fixed cubic (four coefficients per evaluation).
package horner_pkg;
    localparam int NUM_COEF  = 4;
    // Ring bit that is set on the edge sampling the constant term
    localparam int CAP_TAP   = 1;
    // Start value chosen so that the fourth edge after reset sees CAP_TAP
    localparam int INIT_POS  = (CAP_TAP + 1) % NUM_COEF;
    localparam logic [NUM_COEF-1:0] RING_INIT = NUM_COEF'(1) << INIT_POS;
endpackage

// File: rtl/horner_ring.sv
// One-hot phase ring: rotates left one place per clock and flags the
// cycle in which the last coefficient is on the input.
// Assumes rst_n is held low for at least one rising edge before use.
module horner_ring
    import horner_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic cap
);
    logic [NUM_COEF-1:0] ring_q;

    // Rotate the single set bit; reset loads the aligned start value
    always_ff @(posedge clk) begin
        if (!rst_n) ring_q <= RING_INIT;
        else        ring_q <= {ring_q[NUM_COEF-2:0], ring_q[NUM_COEF-1]};
    end

    assign cap = ring_q[CAP_TAP];

    p_ring_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(ring_q) == 1);

    p_ring_rotate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        ring_q == {$past(ring_q[NUM_COEF-2:0]), $past(ring_q[NUM_COEF-1])});
endmodule

// File: rtl/horner_mac.sv
// Horner multiply-accumulate stage: acc <= x * (ai + acc), modulo 2^OUT_W.
// raw = acc + ai is the polynomial value once ai carries the constant term.
// Assumes OUT_W >= COEF_W and OUT_W > PT_W.
module horner_mac #(
    parameter int COEF_W = 3,
    parameter int PT_W   = 2,
    parameter int OUT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [COEF_W-1:0] ai,
    input  logic [PT_W-1:0]   x,
    output logic [OUT_W-1:0]  raw
);
    logic [OUT_W-1:0] acc_q;
    logic [OUT_W-1:0] sum;
    logic [OUT_W-1:0] prod;

    // Truncated sum and product feeding the accumulator
    always_comb begin
        sum  = acc_q + OUT_W'(ai);
        prod = sum * OUT_W'(x);
    end

    assign raw = sum;

    // Accumulate, or restart at zero after the constant term
    always_ff @(posedge clk) begin
        if (!rst_n || restart) acc_q <= '0;
        else                   acc_q <= prod;
    end

    p_acc_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(restart) |-> acc_q == '0);
endmodule

// File: rtl/horner_eval.sv
// Serial cubic evaluator: coefficients arrive one per clock, highest first,
// x held constant; fx updates only with the completed value.
// Assumes evaluations start on the first cycle after reset release and
// follow each other every four cycles.
module horner_eval #(
    parameter int COEF_W = 3,
    parameter int PT_W   = 2,
    parameter int OUT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COEF_W-1:0] ai,
    input  logic [PT_W-1:0]   x,
    output logic [OUT_W-1:0]  fx
);
    logic             cap;
    logic [OUT_W-1:0] raw;
    logic [OUT_W-1:0] fx_q;

    horner_ring u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap)
    );

    horner_mac #(
        .COEF_W (COEF_W),
        .PT_W   (PT_W),
        .OUT_W  (OUT_W)
    ) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cap),
        .ai      (ai),
        .x       (x),
        .raw     (raw)
    );

    // Capture the finished value only in the flagged phase
    always_ff @(posedge clk) begin
        if (!rst_n)   fx_q <= '0;
        else if (cap) fx_q <= raw;
    end

    assign fx = fx_q;

    p_fx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cap) |-> $stable(fx));

    p_fx_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(cap) |-> fx == $past(raw));
endmodule

// File: tb/test_horner_eval.sv
module test_horner_eval;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] ai_d = '0;
    logic [1:0] x_d = '0;
    logic [3:0] ai_w = '0;
    logic [2:0] x_w = '0;
    logic [8:0]  fx_d;
    logic [5:0]  fx_n;
    logic [15:0] fx_w;

    int checks = 0;
    int errors = 0;
    int prev = 0;

    always #4 clk = ~clk;

    horner_eval i_horner_eval (
        .clk(clk), .rst_n(rst_n), .ai(ai_d), .x(x_d), .fx(fx_d));

    horner_eval #(.COEF_W(3), .PT_W(2), .OUT_W(6)) i_horner_eval_narrow (
        .clk(clk), .rst_n(rst_n), .ai(ai_d), .x(x_d), .fx(fx_n));

    horner_eval #(.COEF_W(4), .PT_W(3), .OUT_W(16)) i_horner_eval_wide (
        .clk(clk), .rst_n(rst_n), .ai(ai_w), .x(x_w), .fx(fx_w));

    // {x, c3, c2, c1, c0}
    localparam int NV = 8;
    localparam int VEC [NV][5] = '{
        '{3, 5, 6, 2, 0},
        '{3, 7, 7, 7, 7},
        '{0, 7, 6, 5, 4},
        '{1, 1, 2, 3, 4},
        '{2, 0, 7, 5, 2},
        '{3, 0, 0, 0, 0},
        '{2, 7, 0, 0, 1},
        '{3, 4, 3, 2, 1}
    };

    function automatic int poly(int xv, int c3, int c2, int c1, int c0);
        return ((c3 * xv + c2) * xv + c1) * xv + c0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts and ends at a falling edge
    task automatic run_eval(int xv, int c3, int c2, int c1, int c0);
        int cs [4];
        int full;
        cs = '{c3, c2, c1, c0};
        full = poly(xv, c3, c2, c1, c0);
        x_d = 2'(xv);
        x_w = 3'(xv);
        for (int i = 0; i < 4; i++) begin
            ai_d = 3'(cs[i]);
            ai_w = 4'(cs[i]);
            @(posedge clk);
            @(negedge clk);
            if (i < 3) begin
                check("R4 hold", int'(fx_d), prev % 512);
            end else begin
                check("R2 value", int'(fx_d), full % 512);
                check("R3 wrap", int'(fx_n), full % 64);
                check("R7 wide", int'(fx_w), full % 65536);
            end
        end
        prev = full;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ai_d = '0;
        ai_w = '0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset fx", int'(fx_d), 0);
        check("R1 reset fx wide", int'(fx_w), 0);
        prev = 0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // Table walk, back-to-back evaluations (R5, R6 by alignment)
        for (int k = 0; k < NV; k++)
            run_eval(VEC[k][0], VEC[k][1], VEC[k][2], VEC[k][3], VEC[k][4]);

        // R7 directed worked examples
        run_eval(2, 0, 7, 5, 2);
        check("R7 wide 40", int'(fx_w), 40);
        run_eval(3, 5, 6, 2, 0);
        check("R7 default 195", int'(fx_d), 195);

        // R8 x = 0 leaves only c0
        run_eval(0, 7, 7, 7, 3);
        check("R8 x zero", int'(fx_d), 3);

        // R6 a large result followed by a small one must not leak
        run_eval(3, 7, 7, 7, 7);
        run_eval(1, 0, 0, 0, 1);
        check("R6 restart", int'(fx_d), 1);

        // R1 reset in mid evaluation realigns the phase
        x_d = 2'd3;
        ai_d = 3'd7;
        @(posedge clk);
        @(negedge clk);
        ai_d = 3'd7;
        @(posedge clk);
        do_reset();
        run_eval(2, 1, 0, 0, 0);
        check("R1 realign", int'(fx_d), 8);

        // R3 wrap on the narrow instance: 280 mod 64 = 24
        run_eval(3, 7, 7, 7, 7);
        check("R3 narrow 24", int'(fx_n), 24);

        // R5 phase period: three more idle-coefficient edges keep fx
        x_d = 2'd1;
        ai_d = 3'd5;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R5 period hold", int'(fx_d), 280);
        end
        @(posedge clk);
        @(negedge clk);
        check("R5 period capture", int'(fx_d), 20);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule